// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block holds a small, fully associative set of segment descriptors. Each descriptor pairs an effective-segment word with a virtual-segment word. The effective-segment word keeps the upper effective-address bits and a valid flag. The virtual-segment word carries a two-bit segment-size code in its top bits, plus protection-key, no-execute and large-page flags that this block stores but does not interpret. Every cycle the lookup port compares one effective address against all descriptors. A match against a 256 MB segment and a match against a 1 TB segment are tested side by side, and the size code of each entry decides which kind of match counts for it. One cycle later the lookup port reports whether a descriptor hit, its index and its virtual-segment word.

A command port performs one operation per cycle. It can write a descriptor after checking the write, read back either word of a descriptor, invalidate the descriptor that matches an address, or invalidate all descriptors except entry 0. The block does not hold any translation cache itself. When an invalidation removes a live descriptor, it raises a one-cycle flush request so that downstream translation caches can be emptied. Support for 1 TB segments is selected by a static enable input.

Top module: `slb_array`

## Requirements
- R1: After synchronous reset every descriptor is all zeros and invalid. Any lookup then misses, `cmd_err` and `flush_req` are low, and reading back the effective-segment word of slot 0 returns zero.
- R2: Op code 1 (write) takes the slot from `cmd_addr[11:0]`. It stores `cmd_addr & 64'hFFFF_FFFF_F800_0000` as the effective-segment word, which keeps the segment bits [63:28] and the valid flag at bit 27 and drops the slot number. It stores `cmd_data` unchanged as the virtual-segment word.
- R3: A write whose slot field is at or above NUM_ENTRIES pulses `cmd_err` for one cycle, one cycle after the command, and changes no descriptor.
- R4: The size code is `cmd_data[63:62]`: 00 means 256 MB and 01 means 1 TB. A write carrying code 10 or 11, or carrying 01 while `en_1t` is low, pulses `cmd_err` and changes no descriptor.
- R5: The lookup result is registered and appears one cycle after `lk_ea` is applied. Entry i hits in either of two cases. In the first, its effective-segment word equals {`lk_ea[63:28]`, valid=1, zeros} and its size code is 00. In the second, it equals {`lk_ea[63:40]`, twelve zeros, valid=1, zeros} and its size code is 01.
- R6: When several entries hit, `lk_idx` reports the lowest index and `lk_vsid` carries that entry's virtual-segment word. On a miss, `lk_hit`, `lk_idx` and `lk_vsid` are all zero.
- R7: Op code 2 returns the effective-segment word and op code 3 returns the virtual-segment word of slot `cmd_addr[11:0]` on `cmd_rdata`, one cycle after the command. A slot at or above NUM_ENTRIES instead pulses `cmd_err` and returns zero.
- R8: Op code 4 looks up `cmd_addr` under the rule of R5. On a hit it clears only the valid flag of the lowest matching entry, keeps the rest of that word, and pulses `flush_req` one cycle later. On a miss nothing changes and no flush is raised.
- R9: Op code 5 clears the valid flag of every entry except entry 0. It pulses `flush_req` one cycle later if and only if at least one of entries 1 to NUM_ENTRIES-1 was valid.
- R10: Op code 0 and the unused codes 6 and 7 change no state and raise neither `cmd_err` nor `flush_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_1t | input | 1 | Static enable for 1 TB segment writes |
| lk_ea | input | 64 | Effective address to look up |
| lk_hit | output | 1 | Registered lookup hit |
| lk_idx | output | $clog2(NUM_ENTRIES) | Index of the lowest hitting entry |
| lk_vsid | output | 64 | Virtual-segment word of the hitting entry |
| cmd_op | input | 3 | Command code (0 none, 1 write, 2 read ESID, 3 read VSID, 4 invalidate one, 5 invalidate all) |
| cmd_addr | input | 64 | Address operand: slot number or effective address |
| cmd_data | input | 64 | Data operand for writes |
| cmd_err | output | 1 | One-cycle illegal-operation pulse |
| cmd_rdata | output | 64 | Read-back data, held until the next read |
| flush_req | output | 1 | One-cycle downstream translation flush request |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This holds for the lookup outputs after `lk_ea` changes, and for `cmd_err`, `cmd_rdata` and `flush_req` after a command. A lookup applied in the same cycle as a write or an invalidation still sees the old contents. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It withdraws the command at that moment, before the following rising edge can overwrite the result. Effects on storage, such as a rejected write leaving a slot unchanged or a cleared valid flag, are confirmed through a later read-back or lookup that follows the same one-edge rule.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int WORD_W    = 64;
  localparam int SLOT_W    = 12;
  localparam int SEG_LO    = 28;  // low bit of a 256 MB segment number
  localparam int SEG1T_LO  = 40;  // low bit of a 1 TB segment number
  localparam int VALID_BIT = 27;
  localparam int SIZE_HI   = 63;

  localparam logic [1:0] SZ_256M = 2'b00;
  localparam logic [1:0] SZ_1T   = 2'b01;

  localparam logic [WORD_W-1:0] ESID_KEEP =
    {{(WORD_W-VALID_BIT){1'b1}}, {VALID_BIT{1'b0}}};

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_WRITE   = 3'd1,
    OP_RD_ESID = 3'd2,
    OP_RD_VSID = 3'd3,
    OP_INV_ONE = 3'd4,
    OP_INV_ALL = 3'd5
  } slb_op_e;
endpackage

// File: rtl/slb_prio_enc.sv
module slb_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [WORD_W-1:SEG_LO] ea_seg,
  input  logic [WORD_W-1:0]      esid_q [N],
  input  logic [WORD_W-1:0]      vsid_q [N],
  output logic                   hit,
  output logic [IDX_W-1:0]       idx,
  output logic [WORD_W-1:0]      vsid,
  output logic [N-1:0]           cand
);
  logic [WORD_W-1:0] key_small;
  logic [WORD_W-1:0] key_large;

  assign key_small = {ea_seg, 1'b1, {VALID_BIT{1'b0}}};
  assign key_large = {ea_seg[WORD_W-1:SEG1T_LO], {(SEG1T_LO-SEG_LO){1'b0}},
                      1'b1, {VALID_BIT{1'b0}}};

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [1:0] sz;
    assign sz = vsid_q[g][SIZE_HI -: 2];
    assign cand[g] = ((esid_q[g] == key_small) && (sz == SZ_256M)) ||
                     ((esid_q[g] == key_large) && (sz == SZ_1T));
  end

  slb_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .req (cand),
    .any (hit),
    .idx (idx)
  );

  assign vsid = hit ? vsid_q[idx] : '0;
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check
  import slb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        size_code,
  input  logic              en_1t,
  output logic              slot_ok,
  output logic              wr_ok
);
  logic size_ok;

  assign slot_ok = (slot < SLOT_W'(N));
  always_comb begin
    unique case (size_code)
      SZ_256M: size_ok = 1'b1;
      SZ_1T:   size_ok = en_1t;
      default: size_ok = 1'b0;
    endcase
  end
  assign wr_ok = slot_ok && size_ok;
endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_1t,
  input  logic [63:0]       lk_ea,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [63:0]       lk_vsid,
  input  logic [2:0]        cmd_op,
  input  logic [63:0]       cmd_addr,
  input  logic [63:0]       cmd_data,
  output logic              cmd_err,
  output logic [63:0]       cmd_rdata,
  output logic              flush_req
);
  localparam int N = NUM_ENTRIES;

  logic [WORD_W-1:0] esid_q [N];
  logic [WORD_W-1:0] vsid_q [N];
  logic [N-1:0]      valid_vec;

  for (genvar g = 0; g < N; g++) begin : g_valid
    assign valid_vec[g] = esid_q[g][VALID_BIT];
  end

  // lookup path
  logic              lk_any;
  logic [IDX_W-1:0]  lk_sel;
  logic [WORD_W-1:0] lk_word;
  logic [N-1:0]      lk_cand;

  slb_match #(.N(N), .IDX_W(IDX_W)) u_lk_match (
    .ea_seg (lk_ea[WORD_W-1:SEG_LO]),
    .esid_q (esid_q),
    .vsid_q (vsid_q),
    .hit    (lk_any),
    .idx    (lk_sel),
    .vsid   (lk_word),
    .cand   (lk_cand)
  );

  // invalidate-by-address path
  logic              inv_any;
  logic [IDX_W-1:0]  inv_sel;
  logic [WORD_W-1:0] inv_word;
  logic [N-1:0]      inv_cand;

  slb_match #(.N(N), .IDX_W(IDX_W)) u_inv_match (
    .ea_seg (cmd_addr[WORD_W-1:SEG_LO]),
    .esid_q (esid_q),
    .vsid_q (vsid_q),
    .hit    (inv_any),
    .idx    (inv_sel),
    .vsid   (inv_word),
    .cand   (inv_cand)
  );

  // command checks
  logic             slot_ok;
  logic             wr_ok;
  logic [IDX_W-1:0] slot_idx;

  slb_wr_check #(.N(N)) u_chk (
    .slot      (cmd_addr[SLOT_W-1:0]),
    .size_code (cmd_data[SIZE_HI -: 2]),
    .en_1t     (en_1t),
    .slot_ok   (slot_ok),
    .wr_ok     (wr_ok)
  );

  assign slot_idx = cmd_addr[IDX_W-1:0];

  logic unused_bits;
  assign unused_bits = &{1'b0, lk_ea[SEG_LO-1:0], inv_word, lk_cand, inv_cand};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        esid_q[i] <= '0;
        vsid_q[i] <= '0;
      end
      lk_hit    <= 1'b0;
      lk_idx    <= '0;
      lk_vsid   <= '0;
      cmd_err   <= 1'b0;
      cmd_rdata <= '0;
      flush_req <= 1'b0;
    end else begin
      lk_hit    <= lk_any;
      lk_idx    <= lk_sel;
      lk_vsid   <= lk_word;
      cmd_err   <= 1'b0;
      flush_req <= 1'b0;
      case (slb_op_e'(cmd_op))
        OP_WRITE: begin
          if (wr_ok) begin
            esid_q[slot_idx] <= cmd_addr & ESID_KEEP;
            vsid_q[slot_idx] <= cmd_data;
          end else begin
            cmd_err <= 1'b1;
          end
        end
        OP_RD_ESID: begin
          if (slot_ok) cmd_rdata <= esid_q[slot_idx];
          else begin
            cmd_err   <= 1'b1;
            cmd_rdata <= '0;
          end
        end
        OP_RD_VSID: begin
          if (slot_ok) cmd_rdata <= vsid_q[slot_idx];
          else begin
            cmd_err   <= 1'b1;
            cmd_rdata <= '0;
          end
        end
        OP_INV_ONE: begin
          if (inv_any) begin
            esid_q[inv_sel][VALID_BIT] <= 1'b0;
            flush_req <= 1'b1;
          end
        end
        OP_INV_ALL: begin
          for (int i = 1; i < N; i++) esid_q[i][VALID_BIT] <= 1'b0;
          flush_req <= |valid_vec[N-1:1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd_op,
  input logic [63:0]      cmd_addr,
  input logic [63:0]      cmd_data,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx,
  input logic [63:0]      lk_vsid,
  input logic             cmd_err,
  input logic             flush_req
);
  logic slot_high;
  assign slot_high = (cmd_addr[11:0] >= 12'(NUM_ENTRIES));

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_idx == '0 && lk_vsid == 64'd0));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (32'(lk_idx) < NUM_ENTRIES));

  p_flush_src_r8: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> ($past(cmd_op) == 3'd4 || $past(cmd_op) == 3'd5));

  p_read_range_r7: assert property (@(posedge clk) disable iff (rst)
    ((cmd_op == 3'd2 || cmd_op == 3'd3) && slot_high) |=> cmd_err);

  p_bad_size_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd1 && cmd_data[63]) |=> cmd_err);

  p_bad_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd1 && slot_high) |=> cmd_err);

  p_err_src_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> ($past(cmd_op) == 3'd1 || $past(cmd_op) == 3'd2 ||
                 $past(cmd_op) == 3'd3));
endmodule

bind slb_array slb_array_chk #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk_bind (
  .clk       (clk),
  .rst       (rst),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data),
  .lk_hit    (lk_hit),
  .lk_idx    (lk_idx),
  .lk_vsid   (lk_vsid),
  .cmd_err   (cmd_err),
  .flush_req (flush_req)
);

// File: tb/slb_array_tb.sv
module slb_array_tb;
  localparam int N     = 16;
  localparam int IDX_W = $clog2(N);

  logic             clk = 1'b0;
  logic             rst;
  logic             en_1t;
  logic [63:0]      lk_ea;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic [63:0]      lk_vsid;
  logic [2:0]       cmd_op;
  logic [63:0]      cmd_addr;
  logic [63:0]      cmd_data;
  logic             cmd_err;
  logic [63:0]      cmd_rdata;
  logic             flush_req;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  slb_array #(.NUM_ENTRIES(N)) u_dut (
    .clk(clk), .rst(rst), .en_1t(en_1t), .lk_ea(lk_ea),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_vsid(lk_vsid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_err(cmd_err), .cmd_rdata(cmd_rdata), .flush_req(flush_req)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] addr;
    logic [63:0] data;
    logic        err;
    logic        chk_rd;
    logic [63:0] rd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 64'h0000_0001_1800_0000, 64'h1234,                1'b0, 1'b0, 64'h0},
    '{3'd2, 64'h0,                   64'h0,                   1'b0, 1'b1, 64'h0000_0001_1800_0000},
    '{3'd3, 64'h0,                   64'h0,                   1'b0, 1'b1, 64'h1234},
    '{3'd1, 64'h0000_0001_1800_0010, 64'h1,                   1'b1, 1'b0, 64'h0},
    '{3'd1, 64'h0000_0001_1800_0003, 64'h8000_0000_0000_0001, 1'b1, 1'b0, 64'h0},
    '{3'd1, 64'h0000_0001_1800_0003, 64'hC000_0000_0000_0001, 1'b1, 1'b0, 64'h0},
    '{3'd1, 64'h0000_0200_0800_0005, 64'h4000_0000_0000_0ABC, 1'b0, 1'b0, 64'h0},
    '{3'd3, 64'h5,                   64'h0,                   1'b0, 1'b1, 64'h4000_0000_0000_0ABC},
    '{3'd2, 64'h10,                  64'h0,                   1'b1, 1'b1, 64'h0},
    '{3'd3, 64'hFFF,                 64'h0,                   1'b1, 1'b1, 64'h0},
    '{3'd1, 64'h0000_0001_1800_0002, 64'h5555,                1'b0, 1'b0, 64'h0},
    '{3'd1, 64'h0000_0003_0800_0007, 64'h77,                  1'b0, 1'b0, 64'h0},
    '{3'd2, 64'h7,                   64'h0,                   1'b0, 1'b1, 64'h0000_0003_0800_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one command, sample its results one edge later
  task automatic cmd(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_op = 3'd0;
  endtask

  task automatic look(input logic [63:0] ea);
    @(negedge clk);
    lk_ea = ea;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; en_1t = 1'b1; lk_ea = 64'h0;
    cmd_op = 3'd0; cmd_addr = 64'h0; cmd_data = 64'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    look(64'h0);
    check("R1 hit", {63'd0, lk_hit}, 64'd0);
    check("R1 err", {63'd0, cmd_err}, 64'd0);
    check("R1 flush", {63'd0, flush_req}, 64'd0);
    cmd(3'd2, 64'h0, 64'h0);
    check("R1 esid0", cmd_rdata, 64'h0);

    // table walk: R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      cmd(TBL[i].op, TBL[i].addr, TBL[i].data);
      check("R2/R3/R4/R7 err", {63'd0, cmd_err}, {63'd0, TBL[i].err});
      check("R10 flush", {63'd0, flush_req}, 64'd0);
      if (TBL[i].chk_rd) check("R2/R7 rdata", cmd_rdata, TBL[i].rd);
    end

    // R3 R4: rejected writes left slot 3 untouched
    cmd(3'd2, 64'h3, 64'h0);
    check("R3 slot3 esid", cmd_rdata, 64'h0);
    cmd(3'd3, 64'h3, 64'h0);
    check("R4 slot3 vsid", cmd_rdata, 64'h0);

    // R5 R6 lookups
    look(64'h0000_0001_1000_0123);
    check("R6 lowest hit", {63'd0, lk_hit}, 64'd1);
    check("R6 lowest idx", 64'(lk_idx), 64'd0);
    check("R6 lowest vsid", lk_vsid, 64'h1234);
    look(64'h0000_0212_3456_7890);
    check("R5 1T idx", 64'(lk_idx), 64'd5);
    check("R5 1T vsid", lk_vsid, 64'h4000_0000_0000_0ABC);
    look(64'h0000_0003_0FFF_FFFF);
    check("R5 256M idx", 64'(lk_idx), 64'd7);
    look(64'h0000_0004_0000_0000);
    check("R6 miss hit", {63'd0, lk_hit}, 64'd0);
    check("R6 miss vsid", lk_vsid, 64'h0);

    // R5 size gating: 1T-shaped key with 256M code must miss a 1T-only match
    cmd(3'd1, 64'h0000_0500_0800_0009, 64'h99);
    look(64'h0000_0500_1000_0000);
    check("R5 size gate miss", {63'd0, lk_hit}, 64'd0);
    look(64'h0000_0500_0000_0000);
    check("R5 size gate 256M idx", 64'(lk_idx), 64'd9);

    // R4 1T disabled
    en_1t = 1'b0;
    cmd(3'd1, 64'h0000_0600_0800_000A, 64'h4000_0000_0000_0001);
    check("R4 1T off err", {63'd0, cmd_err}, 64'd1);
    en_1t = 1'b1;
    cmd(3'd3, 64'hA, 64'h0);
    check("R4 1T off unchanged", cmd_rdata, 64'h0);

    // R10 unused op
    cmd(3'd6, 64'h0000_0001_1800_0000, 64'h0);
    check("R10 op6 err", {63'd0, cmd_err}, 64'd0);
    check("R10 op6 flush", {63'd0, flush_req}, 64'd0);
    look(64'h0000_0001_1000_0000);
    check("R10 op6 no change", 64'(lk_idx), 64'd0);

    // R8 invalidate by address
    cmd(3'd4, 64'h0000_0001_1000_0000, 64'h0);
    check("R8 flush first", {63'd0, flush_req}, 64'd1);
    look(64'h0000_0001_1000_0000);
    check("R8 next idx", 64'(lk_idx), 64'd2);
    check("R8 next vsid", lk_vsid, 64'h5555);
    cmd(3'd4, 64'h0000_0001_1000_0000, 64'h0);
    check("R8 flush second", {63'd0, flush_req}, 64'd1);
    cmd(3'd4, 64'h0000_0001_1000_0000, 64'h0);
    check("R8 miss no flush", {63'd0, flush_req}, 64'd0);
    cmd(3'd2, 64'h0, 64'h0);
    check("R8 valid cleared", cmd_rdata, 64'h0000_0001_1000_0000);

    // R9 invalidate all spares entry 0
    cmd(3'd1, 64'h0000_0001_1800_0000, 64'h1234);
    cmd(3'd5, 64'h0, 64'h0);
    check("R9 flush", {63'd0, flush_req}, 64'd1);
    look(64'h0000_0001_1000_0000);
    check("R9 entry0 kept", {63'd0, lk_hit}, 64'd1);
    look(64'h0000_0003_0000_0000);
    check("R9 entry7 gone", {63'd0, lk_hit}, 64'd0);
    cmd(3'd5, 64'h0, 64'h0);
    check("R9 no flush", {63'd0, flush_req}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule